// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that sits on a plain 32-bit register bus. Software sets a reload value and a clock divider, turns the watchdog on, and then has to kick it often enough to keep it from expiring. The counter is reloaded from a 12-bit field that supplies only its upper bits. It counts down once per divided tick. When it expires, the block sets a sticky status flag and can raise a level interrupt, send out a reset pulse of selectable length, or do both.

Writes are guarded against runaway software. Each writable register checks a key pattern inside the written word, and a write with a wrong key is dropped. A kick takes effect only when one exact 32-bit code is written. The block decodes the word offset from address bits [3:2] and ignores the other address bits. Reads are combinational while the read strobe is high, and they return 0 when it is low. A build parameter can select a registered read instead.

Top module: `wdog_keyed`

## Requirements
- R1: A write to the control register at offset 0x0 takes effect only if wdata[23:12] = 0xABC. Any other key leaves every control field unchanged.
- R2: The control fields are: bit 0 watchdog enable, bit 1 reset-pulse enable, bit 2 interrupt enable, bits [5:4] pulse-length code. A read of offset 0x0 returns exactly these bits, and the key bits and all other bits read as zero.
- R3: A write to the counter-setup register at offset 0x4 takes effect only if wdata[31:14] = 18'h00248, which is 0x0092 in bits [31:16] and zero in bits [15:14]. This register holds the reload field in bits [13:2] and the divider select in bits [1:0]. It reads back in the same positions, with the other bits zero.
- R4: Writing exactly 0x00001999 to offset 0x8 reloads the counter, restarts the divider and clears the status flag. Any other value written to offset 0x8 does nothing. A kick given in time postpones expiry.
- R5: The reload value is {field, LOW_W ones}, where LOW_W defaults to 12. The counter drops by one on each divided tick, so expiry comes reload × divisor clock cycles after the reload edge.
- R6: The divider select values 0, 1, 2 and 3 divide the clock by 8, 64, 512 and 4096.
- R7: The status flag is bit 0 of offset 0xC and is read-only. It sets on expiry and holds until a valid kick or until a valid control write switches enable from 0 to 1. Writes to 0xC are ignored.
- R8: wdt_irq is high exactly while the status flag and the interrupt enable are both 1.
- R9: If the reset-pulse enable is set, each expiry gives exactly one wdt_rst pulse. The pulse lasts 2, 4, 8 or 16 cycles for length codes 0, 1, 2 and 3. It starts in the same cycle as the status flag.
- R10: A valid control write that clears enable stops the countdown, so no expiry happens while the watchdog is off. Turning it back on reloads the counter.
- R11: After reset, all registers read zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (4) | Byte address; bits [3:2] select the register |
| wdata | input | DATA_W (32) | Write data, including the key |
| rdata | output | DATA_W (32) | Read data |
| wdt_rst | output | 1 | Reset pulse on expiry |
| wdt_irq | output | 1 | Level interrupt on expiry |

## Verification
The countdown is run with all four divider selects and with two reload fields. This separates a wrong divisor from a wrong reload width or a wrong number of low ones. Each of the four pulse-length codes is run to expiry, and the measured pulse width tells the codes apart. Separate runs with only the interrupt enabled and only the reset enabled show that the two outputs are independent. Near-miss keys and near-miss kick codes are checked, including a setup key with bits [15:14] set and a kick code with one stray high bit. A kick in mid-count and a disable/re-enable sequence show the difference between a postponed timer and one that expires on time.

// File: rtl/wdog_keyed_pkg.sv
package wdog_keyed_pkg;

   localparam logic [11:0] CTRL_KEY  = 12'hABC;
   localparam logic [17:0] SETUP_KEY = 18'h00248;
   localparam logic [31:0] KICK_CODE = 32'h0000_1999;

   typedef enum logic [1:0] {
      REG_CTRL  = 2'd0,
      REG_SETUP = 2'd1,
      REG_KICK  = 2'd2,
      REG_STAT  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic [1:0] plen;
      logic       irq_on;
      logic       rst_on;
      logic       en;
   } ctrl_t;

   typedef struct packed {
      logic [11:0] field;
      logic [1:0]  dsel;
   } setup_t;

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
   parameter int SEL_W = 2,
   parameter int BASE  = 3,
   parameter int STEP  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [SEL_W-1:0] dsel,
   output logic             tick
);
   localparam int PRE_W = BASE + STEP * ((1 << SEL_W) - 1);

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] lim;

   always_comb begin
      lim  = PRE_W'((1 << (BASE + STEP * int'(dsel))) - 1);
      tick = run && (pre_q >= lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pre_q <= '0;
      else if (clr || tick) pre_q <= '0;
      else if (run)        pre_q <= pre_q + 1'b1;
   end

   p_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   p_idle_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(pre_q));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int HI_W  = 12,
   parameter int LOW_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [HI_W-1:0] field,
   input  logic            tick,
   output logic            expire
);
   localparam int CNT_W = HI_W + LOW_W;

   logic [CNT_W-1:0] cnt_q;

   assign expire = tick && !load && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (load)                  cnt_q <= {field, {LOW_W{1'b1}}};
      else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !load) |=> cnt_q == '0);
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
   parameter int LEN_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic [LEN_W-1:0] plen,
   output logic             pulse_o
);
   localparam int PC_W = $clog2((2 << ((1 << LEN_W) - 1)) + 1);

   logic [PC_W-1:0] pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pc_q <= '0;
      else if (fire)       pc_q <= PC_W'(2 << int'(plen));
      else if (pc_q != '0) pc_q <= pc_q - 1'b1;
   end

   assign pulse_o = (pc_q != '0);

   p_pulse_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_o) |=> pulse_o);

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
   import wdog_keyed_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 32,
   parameter int LOW_W    = 12,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              wdt_rst,
   output logic              wdt_irq
);
   localparam int HI_W = 12;

   if (DATA_W != 32) begin : g_bad_dw
      $error("wdog_keyed: DATA_W must be 32");
   end
   if (ADDR_W < 4) begin : g_bad_aw
      $error("wdog_keyed: ADDR_W must be at least 4");
   end
   if (LOW_W < 1 || LOW_W > 20) begin : g_bad_low
      $error("wdog_keyed: LOW_W out of range");
   end

   reg_sel_e sel;
   ctrl_t    ctrl_q;
   setup_t   setup_q;
   logic     stat_q;
   logic     ctrl_ok, setup_ok, kick_ok, en_rise, load, run, tick, expire;
   logic [DATA_W-1:0] rd_mux;
   logic     unused_addr;

   assign sel         = reg_sel_e'(addr[3:2]);
   assign unused_addr = ^addr;

   assign ctrl_ok  = wr_en && (sel == REG_CTRL)  && (wdata[23:12] == CTRL_KEY);
   assign setup_ok = wr_en && (sel == REG_SETUP) && (wdata[31:14] == SETUP_KEY);
   assign kick_ok  = wr_en && (sel == REG_KICK)  && (wdata == KICK_CODE);
   assign en_rise  = ctrl_ok && wdata[0] && !ctrl_q.en;
   assign load     = kick_ok || en_rise;
   assign run      = ctrl_q.en && !stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         setup_q <= '0;
      end else begin
         if (ctrl_ok)  ctrl_q  <= ctrl_t'({wdata[5:4], wdata[2:0]});
         if (setup_ok) setup_q <= setup_t'(wdata[13:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat_q <= 1'b0;
      else if (load)   stat_q <= 1'b0;
      else if (expire) stat_q <= 1'b1;
   end

   wdog_prescale #(.SEL_W(2), .BASE(3), .STEP(3)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .clr(load),
      .dsel(setup_q.dsel), .tick(tick)
   );

   wdog_counter #(.HI_W(HI_W), .LOW_W(LOW_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .field(setup_q.field),
      .tick(tick), .expire(expire)
   );

   wdog_pulse #(.LEN_W(2)) u_pulse (
      .clk(clk), .rst_n(rst_n), .fire(expire && ctrl_q.rst_on),
      .plen(ctrl_q.plen), .pulse_o(wdt_rst)
   );

   assign wdt_irq = stat_q && ctrl_q.irq_on;

   always_comb begin
      rd_mux = '0;
      case (sel)
         REG_CTRL:  rd_mux = DATA_W'({ctrl_q.plen, 1'b0, ctrl_q.irq_on,
                                      ctrl_q.rst_on, ctrl_q.en});
         REG_SETUP: rd_mux = DATA_W'(setup_q);
         REG_STAT:  rd_mux = DATA_W'(stat_q);
         default:   rd_mux = '0;
      endcase
   end

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata <= '0;
         else        rdata <= rd_en ? rd_mux : '0;
      end
   end else begin : g_rd_comb
      assign rdata = rd_en ? rd_mux : '0;
   end

   p_bad_ctrl_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == REG_CTRL && wdata[23:12] != CTRL_KEY) |=> $stable(ctrl_q));
   p_bad_setup_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == REG_SETUP && wdata[31:14] != SETUP_KEY) |=> $stable(setup_q));
   p_kick_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      kick_ok |=> (!stat_q && !wdt_irq));
   p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q && !load) |=> stat_q);
   p_pulse_with_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_rst) |-> stat_q);

endmodule

// File: tb/tb_wdog_keyed.sv
module tb_wdog_keyed;
   localparam int TB_LOW = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        wdt_rst, wdt_irq;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   wdog_keyed #(.ADDR_W(4), .DATA_W(32), .LOW_W(TB_LOW), .READ_REG(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .wdt_rst(wdt_rst), .wdt_irq(wdt_irq)
   );

   // behavioural reference model
   int m_en, m_rsten, m_irqen, m_plen, m_field, m_dsel;
   int m_cnt, m_pre, m_flag, m_pulse;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_rsten = 0; m_irqen = 0; m_plen = 0; m_field = 0; m_dsel = 0;
         m_cnt = 0; m_pre = 0; m_flag = 0; m_pulse = 0;
      end else begin
         bit c_ok, s_ok, k_ok, ld, run, tk, to;
         int div;
         c_ok = wr_en && addr[3:2] == 2'd0 && wdata[23:12] == 12'hABC;
         s_ok = wr_en && addr[3:2] == 2'd1 && wdata[31:16] == 16'h0092 && wdata[15:14] == 2'b00;
         k_ok = wr_en && addr[3:2] == 2'd2 && wdata == 32'h1999;
         ld   = k_ok || (c_ok && wdata[0] && m_en == 0);
         run  = (m_en != 0) && (m_flag == 0);
         div  = 8 << (3 * m_dsel);
         tk   = run && (m_pre >= div - 1);
         to   = tk && !ld && (m_cnt == 1);
         if (to && m_rsten != 0) m_pulse = 2 << m_plen;
         else if (m_pulse > 0)   m_pulse = m_pulse - 1;
         if (ld) m_flag = 0; else if (to) m_flag = 1;
         if (ld) m_cnt = (m_field << TB_LOW) + (1 << TB_LOW) - 1;
         else if (tk && m_cnt > 0) m_cnt = m_cnt - 1;
         if (ld || tk) m_pre = 0; else if (run) m_pre = m_pre + 1;
         if (c_ok) begin
            m_en = wdata[0]; m_rsten = wdata[1]; m_irqen = wdata[2]; m_plen = wdata[5:4];
         end
         if (s_ok) begin
            m_field = wdata[13:2]; m_dsel = wdata[1:0];
         end
      end
   end

   // per-cycle output comparison
   always @(negedge clk) begin
      if (rst_n) begin
         bit e_irq, e_rst;
         e_irq = (m_flag != 0) && (m_irqen != 0);
         e_rst = (m_pulse != 0);
         tests++;
         if (wdt_irq !== e_irq) begin
            fails++;
            $display("FAIL R8 wdt_irq got %0b expected %0b at %0t", wdt_irq, e_irq, $time);
         end
         tests++;
         if (wdt_rst !== e_rst) begin
            fails++;
            $display("FAIL R9 wdt_rst got %0b expected %0b at %0t", wdt_rst, e_rst, $time);
         end
      end
   end

   // pulse width monitor
   int run_len = 0;
   int last_len = 0;
   int pulse_cnt = 0;
   always @(negedge clk) begin
      if (wdt_rst) run_len++;
      else if (run_len != 0) begin
         last_len = run_len; pulse_cnt++; run_len = 0;
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd_exp(input logic [3:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1;
      tests++;
      if (rdata !== exp) begin
         fails++;
         $display("FAIL %s read 0x%0h got 0x%0h expected 0x%0h", tag, a, rdata, exp);
      end
      rd_en = 1'b0;
   endtask

   task automatic chk(input bit got, input bit exp, input string tag);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got %0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic run_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      rd_exp(4'h0, 32'h0, "R11");
      rd_exp(4'h4, 32'h0, "R11");
      rd_exp(4'hC, 32'h0, "R11");
      chk(wdt_irq, 1'b0, "R11");
      chk(wdt_rst, 1'b0, "R11");
      // R1 bad control key
      wr(4'h0, 32'h00AB_D037);
      rd_exp(4'h0, 32'h0, "R1");
      // R3 bad setup keys, then a good one
      wr(4'h4, 32'h0093_0004);
      rd_exp(4'h4, 32'h0, "R3");
      wr(4'h4, 32'h0092_4004);
      rd_exp(4'h4, 32'h0, "R3");
      wr(4'h4, 32'h0092_0004);
      rd_exp(4'h4, 32'h4, "R3");
      // R2 control fields, key reads zero
      wr(4'h0, 32'h00AB_C037);
      rd_exp(4'h0, 32'h37, "R2");
      // R5 reload {1,4'hF}=31 ticks of 8 cycles = 248 cycles
      run_cycles(240);
      rd_exp(4'hC, 32'h0, "R5");
      run_cycles(20);
      rd_exp(4'hC, 32'h1, "R5");
      // R7 status write ignored
      wr(4'hC, 32'h0);
      rd_exp(4'hC, 32'h1, "R7");
      // R4 near-miss kicks ignored, exact kick clears
      wr(4'h8, 32'h0000_1998);
      rd_exp(4'hC, 32'h1, "R4");
      wr(4'h8, 32'h0001_1999);
      rd_exp(4'hC, 32'h1, "R4");
      wr(4'h8, 32'h0000_1999);
      rd_exp(4'hC, 32'h0, "R4");
      chk(wdt_irq, 1'b0, "R4");
      // R10 disable stops, re-enable reloads
      run_cycles(100);
      wr(4'h0, 32'h00AB_C036);
      run_cycles(400);
      rd_exp(4'hC, 32'h0, "R10");
      wr(4'h0, 32'h00AB_C037);
      run_cycles(200);
      rd_exp(4'hC, 32'h0, "R10");
      run_cycles(60);
      rd_exp(4'hC, 32'h1, "R10");
      chk(last_len == 16, 1'b1, "R9");
      // R9 pulse lengths, reload 15 ticks of 8
      wr(4'h4, 32'h0092_0000);
      for (int rl = 0; rl < 3; rl++) begin
         wr(4'h0, 32'h00AB_C003 | (32'(rl) << 4));
         wr(4'h8, 32'h0000_1999);
         run_cycles(140);
         rd_exp(4'hC, 32'h1, "R9");
         chk(wdt_irq, 1'b0, "R8");
         tests++;
         if (last_len != (2 << rl)) begin
            fails++;
            $display("FAIL R9 pulse width got %0d expected %0d", last_len, 2 << rl);
         end
      end
      // R8 interrupt only, no pulse
      begin
         int pc0;
         pc0 = pulse_cnt;
         wr(4'h0, 32'h00AB_C005);
         wr(4'h8, 32'h0000_1999);
         run_cycles(140);
         chk(wdt_irq, 1'b1, "R8");
         chk(pulse_cnt == pc0, 1'b1, "R9");
         wr(4'h0, 32'h00AB_C001);
         chk(wdt_irq, 1'b0, "R8");
         rd_exp(4'hC, 32'h1, "R8");
      end
      // R6 divider selects with reload 15
      for (int ps = 1; ps < 4; ps++) begin
         int d;
         d = 8 << (3 * ps);
         wr(4'h4, 32'h0092_0000 | 32'(ps));
         wr(4'h8, 32'h0000_1999);
         run_cycles(15 * d - 30);
         rd_exp(4'hC, 32'h0, "R6");
         run_cycles(60);
         rd_exp(4'hC, 32'h1, "R6");
      end
      // R4 timely kick postpones expiry
      wr(4'h4, 32'h0092_0000);
      wr(4'h8, 32'h0000_1999);
      run_cycles(100);
      wr(4'h8, 32'h0000_1999);
      run_cycles(60);
      rd_exp(4'hC, 32'h0, "R4");
      run_cycles(80);
      rd_exp(4'hC, 32'h1, "R4");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule